// File: doc/BRIEF.md
# Auto-Restart Fault Timer

This block supervises a switching converter for a sustained low-feedback fault, such as a shorted output. It counts ticks of the converter oscillator for as long as a feedback-below-threshold flag stays asserted. The count restarts whenever feedback rises above the threshold. If the count reaches a programmable limit, the block stops switching and enters a hiccup cycle. Each hiccup cycle is a long off-window followed by a short on-window. With the default durations, the on-window is about 12% of the cycle.

During an on-window, switching is enabled again and the feedback flag is watched. If feedback rises above the threshold at any point in the window, the block returns to normal operation with its fault count cleared. If feedback stays low through the whole window, another off-window begins. The feedback flag comes from an asynchronous comparator, so it passes through a synchronizer before it is used. All durations are counted in oscillator ticks. The defaults assume a 100 kHz tick: 15,000 ticks to detect the fault, 120,000 ticks off and 17,000 ticks on.

Top module: `auto_restart_timer`

## Requirements
- R1: After reset, `sw_enable` is 1 and `fault_active` is 0. Normal operation starts with a cleared fault count.
- R2: With the synchronized feedback-low flag held at 1, ticks 1 to FAULT_TICKS-1 leave the outputs unchanged. On the clock edge that samples tick number FAULT_TICKS, the block enters hiccup-off: `sw_enable`=0 and `fault_active`=1.
- R3: In normal operation, any clock cycle with the synchronized flag at 0 clears the fault count. A run of FAULT_TICKS-1 low ticks, then a tick with feedback high, then another FAULT_TICKS-1 low ticks never raises a fault.
- R4: The hiccup-off window keeps `sw_enable` at 0 and `fault_active` at 1 for exactly OFF_TICKS ticks, whatever the feedback flag does. The edge that samples tick number OFF_TICKS starts the on-window.
- R5: In the on-window, `sw_enable` is 1 and `fault_active` stays 1. If feedback stays low for ON_TICKS ticks, the edge that samples tick ON_TICKS returns to hiccup-off, and the cycle repeats for as long as the fault lasts.
- R6: If the synchronized flag is 0 in any cycle of the on-window, the block returns to normal operation (`fault_active`=0, `sw_enable`=1). A new fault then needs a full run of FAULT_TICKS low ticks.
- R7: Only ticks advance the timers. Holding feedback low with no tick pulses never raises a fault.
- R8: Changes on `fb_low` take effect after SYNC_STAGES clock edges of synchronization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse, one per oscillator period |
| fb_low | input | 1 | Asynchronous flag: feedback is below the auto-restart threshold |
| sw_enable | output | 1 | 1 allows power switching; 0 gates it off |
| fault_active | output | 1 | 1 while in the hiccup cycle, in either its off-window or its on-window |

## Verification
The hardest case to reach is recovery inside the on-window. It needs a complete fault detection followed by a full off-window, and the feedback flag must rise only after the block has switched back on. The bench does not wait for real-time durations. It shrinks all durations through the parameters and steps ticks one at a time. It then releases the flag a few ticks into the on-window and checks that the block is back in normal operation. The bench also checks that re-entering a fault afterwards takes exactly FAULT_TICKS low ticks. A second cycle in which feedback stays low confirms that the on-window falls back into hiccup-off on its last tick.

// File: rtl/art_pkg.sv
// Package: shared types for the auto-restart fault timer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package art_pkg;

    // Supervisor modes: regulating, hiccup gated off, hiccup trial window.
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_REST = 2'd1,
        MODE_PROBE = 2'd2
    } art_mode_t;

endpackage

// File: rtl/art_sync.sv
// Module: art_sync
// Brings an asynchronous level into the clock domain through a chain of
// flops. STAGES = 0 gives a plain wire for inputs that are already
// synchronous.
// Assumes: the level is stable for longer than STAGES clock cycles.
module art_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the input through the flop chain; reset clears it to "not low".
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din} & {STAGES{1'b1}};
            end
            assign dout = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/art_tick_counter.sv
// Module: art_tick_counter
// Counts step pulses from 0 up to LIMIT-1. Clear takes priority over step.
// last is 1 while the count sits at LIMIT-1, so the caller can act on the
// step that completes LIMIT steps.
// Assumes: LIMIT >= 2. The caller stops stepping once last is reached.
module art_tick_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Advance on each step, hold at the top value, and return to zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)            cnt_q <= '0;
        else if (step && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == TOP);

endmodule

// File: rtl/art_mode_fsm.sv
// Module: art_mode_fsm
// Mode control for the auto-restart supervisor. It decides when each timer
// steps and clears, and it derives the two outputs from the registered mode.
// Assumes: tick is a one-cycle pulse, fb_low_s is synchronous, and the
// *_last inputs come from art_tick_counter instances driven by this module.
module art_mode_fsm
    import art_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fb_low_s,
    input  logic detect_last,
    input  logic rest_last,
    input  logic probe_last,
    output logic detect_clear,
    output logic detect_step,
    output logic rest_clear,
    output logic rest_step,
    output logic probe_clear,
    output logic probe_step,
    output logic sw_enable,
    output logic fault_active
);

    art_mode_t mode_q, mode_d;

    // Next-mode decision from the tick, the feedback flag and the timers.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (tick && fb_low_s && detect_last) mode_d = MODE_REST;
            end
            MODE_REST: begin
                if (tick && rest_last) mode_d = MODE_PROBE;
            end
            MODE_PROBE: begin
                if (!fb_low_s)                    mode_d = MODE_RUN;
                else if (tick && probe_last)      mode_d = MODE_REST;
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    // Hold the mode register; reset returns to regulating.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // Timer steering: each timer runs only in its own mode and is cleared outside it.
    always_comb begin
        detect_clear = (mode_q != MODE_RUN) || !fb_low_s;
        detect_step  = tick && fb_low_s;
        rest_clear   = (mode_q != MODE_REST);
        rest_step    = tick;
        probe_clear  = (mode_q != MODE_PROBE);
        probe_step   = tick && fb_low_s;
    end

    assign sw_enable    = (mode_q != MODE_REST);
    assign fault_active = (mode_q != MODE_RUN);

endmodule

// File: rtl/auto_restart_timer.sv
// Module: auto_restart_timer (top)
// Fault supervisor with hiccup auto-restart. It counts oscillator ticks
// while feedback is low. After FAULT_TICKS ticks it alternates an off-window
// of OFF_TICKS with an on-window of ON_TICKS, and it leaves the hiccup cycle
// when feedback recovers during an on-window.
// Assumes: osc_tick is a single-cycle pulse in the clk domain, fb_low may be
// asynchronous, and all durations are at least 2 ticks.
module auto_restart_timer #(
    parameter int FAULT_TICKS = 15000,
    parameter int OFF_TICKS   = 120000,
    parameter int ON_TICKS    = 17000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic fb_low,
    output logic sw_enable,
    output logic fault_active
);

    logic fb_low_s;
    logic detect_clear, detect_step, detect_last;
    logic rest_clear, rest_step, rest_last;
    logic probe_clear, probe_step, probe_last;

    art_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(fb_low), .dout(fb_low_s)
    );

    art_tick_counter #(.LIMIT(FAULT_TICKS)) u_detect (
        .clk(clk), .rst_n(rst_n), .clear(detect_clear),
        .step(detect_step), .last(detect_last)
    );

    art_tick_counter #(.LIMIT(OFF_TICKS)) u_rest (
        .clk(clk), .rst_n(rst_n), .clear(rest_clear),
        .step(rest_step), .last(rest_last)
    );

    art_tick_counter #(.LIMIT(ON_TICKS)) u_probe (
        .clk(clk), .rst_n(rst_n), .clear(probe_clear),
        .step(probe_step), .last(probe_last)
    );

    art_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick), .fb_low_s(fb_low_s),
        .detect_last(detect_last), .rest_last(rest_last), .probe_last(probe_last),
        .detect_clear(detect_clear), .detect_step(detect_step),
        .rest_clear(rest_clear), .rest_step(rest_step),
        .probe_clear(probe_clear), .probe_step(probe_step),
        .sw_enable(sw_enable), .fault_active(fault_active)
    );

endmodule

// File: rtl/auto_restart_timer_checker.sv
// Module: auto_restart_timer_checker
// Temporal properties of the supervisor, attached to the top with bind.
// Assumes: fb_s is the synchronized feedback flag inside the top.
module auto_restart_timer_checker (
    input logic clk,
    input logic rst_n,
    input logic osc_tick,
    input logic fb_s,
    input logic sw_enable,
    input logic fault_active
);

    // R2: a fault can only start on an edge that samples a tick.
    assert_fault_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_active) |-> $past(osc_tick));

    // R3: regulating with feedback high stays regulating.
    assert_high_fb_holds_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_active && !fb_s) |=> !fault_active);

    // R4: the off-window can only end on a tick.
    assert_rest_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_enable && !osc_tick) |=> !sw_enable);

    // R4: switching is never gated outside the hiccup cycle.
    assert_gate_implies_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |-> fault_active);

    // R5: switching comes back only on a tick.
    assert_enable_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_enable) |-> $past(osc_tick));

    // R6: recovery inside the on-window leaves the hiccup cycle.
    assert_probe_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_active && sw_enable && !fb_s) |=> !fault_active);

endmodule

bind auto_restart_timer auto_restart_timer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fb_s(fb_low_s),
    .sw_enable(sw_enable), .fault_active(fault_active)
);

// File: tb/auto_restart_timer_bench.sv
// Directed bench for auto_restart_timer with shortened durations.
module auto_restart_timer_bench;

    localparam int FT = 10;
    localparam int OT = 20;
    localparam int NT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic fb_low = 1'b0;
    logic sw_enable, fault_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    auto_restart_timer #(
        .FAULT_TICKS(FT), .OFF_TICKS(OT), .ON_TICKS(NT), .SYNC_STAGES(2)
    ) u_auto_restart_timer (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fb_low(fb_low),
        .sw_enable(sw_enable), .fault_active(fault_active)
    );

    task automatic check(input string req, input logic en_exp, input logic flt_exp);
        checks++;
        if (sw_enable !== en_exp || fault_active !== flt_exp) begin
            errors++;
            $display("FAIL %s: sw_enable=%b fault_active=%b expected %b %b",
                     req, sw_enable, fault_active, en_exp, flt_exp);
        end
    endtask

    // One tick pulse; returns on a falling edge after it was sampled.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // Change the feedback flag and let it pass the synchronizer.
    task automatic set_fb(input logic v);
        @(negedge clk) fb_low = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        osc_tick = 1'b0;
        fb_low = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 reset state", 1'b1, 1'b0);
    endtask

    task automatic test_detect();
        do_reset();
        set_fb(1'b1);
        ticks(FT - 1);
        check("R2 one tick short of limit", 1'b1, 1'b0);
        ticks(1);
        check("R2 limit reached", 1'b0, 1'b1);
    endtask

    task automatic test_clear();
        do_reset();
        set_fb(1'b1);
        ticks(FT - 1);
        set_fb(1'b0);
        ticks(1);
        set_fb(1'b1);
        ticks(FT - 1);
        check("R3 count cleared by high feedback", 1'b1, 1'b0);
        ticks(1);
        check("R3 fresh run completes", 1'b0, 1'b1);
    endtask

    task automatic test_no_tick();
        do_reset();
        set_fb(1'b1);
        repeat (FT * 8) @(negedge clk);
        check("R7 no ticks, no fault", 1'b1, 1'b0);
        set_fb(1'b0);
    endtask

    task automatic test_sync_latency();
        do_reset();
        set_fb(1'b1);
        ticks(FT - 1);
        @(negedge clk) fb_low = 1'b0;
        osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
        check("R8 tick before flag clears still counts", 1'b0, 1'b1);
        fb_low = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_hiccup();
        do_reset();
        set_fb(1'b1);
        ticks(FT);
        set_fb(1'b0);
        ticks(3);
        check("R4 high feedback ignored in off window", 1'b0, 1'b1);
        set_fb(1'b1);
        ticks(OT - 4);
        check("R4 off window one tick short", 1'b0, 1'b1);
        ticks(1);
        check("R4 on window starts", 1'b1, 1'b1);
        ticks(NT - 1);
        check("R5 on window one tick short", 1'b1, 1'b1);
        ticks(1);
        check("R5 low feedback returns to off", 1'b0, 1'b1);
        ticks(OT);
        check("R5 second on window", 1'b1, 1'b1);
        ticks(2);
        set_fb(1'b0);
        check("R6 recovery in on window", 1'b1, 1'b0);
        set_fb(1'b1);
        ticks(FT - 1);
        check("R6 full detection needed again", 1'b1, 1'b0);
        ticks(1);
        check("R6 new fault after full run", 1'b0, 1'b1);
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_detect();
                test_clear();
                test_no_tick();
                test_sync_latency();
                test_hiccup();
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: run did not finish, expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule